// File: doc/BRIEF.md
# Quadrilateral Corner Editor

The block holds the four corners of a target quadrilateral drawn on a 640 by 480 screen, each corner made of a 10-bit horizontal coordinate and a 9-bit vertical coordinate. All of its state changes only once per displayed frame, on the rising edge of the vertical sync input. Between those edges every output holds its value.

The block has two modes. In the automatic mode (state `MODE_AUTO`) the corners copy, at each frame edge, the raw corner values that an external lookup supplies. A rising edge of the override input moves the block to the manual mode (state `MODE_MANUAL`). The override input is sampled once per frame, and a rise is a 1 after a 0 at the previous frame edge. On the frame edge that enters manual mode, the raw corners are captured, so editing starts from the automatic position. After that, the four direction buttons move one chosen corner by a fixed step per frame, kept inside the screen. The next override rise returns the block to `MODE_AUTO` and reloads the raw corners on that frame edge.

The block also drives the coordinates of the selected corner, for use by a cursor overlay. Drawing the cursor is outside this block.

The state machine has four transitions. `MODE_AUTO` stays in `MODE_AUTO` at a frame edge with no override rise (auto_hold). `MODE_AUTO` goes to `MODE_MANUAL` on an override rise (enter_edit). `MODE_MANUAL` stays in `MODE_MANUAL` at a frame edge with no override rise (edit_step). `MODE_MANUAL` goes to `MODE_AUTO` on an override rise (leave_edit).

Top module: `corner_editor`

## Requirements
- R1: After reset the block is in `MODE_AUTO`, every corner coordinate is 0, and the cursor outputs are 0.
- R2: Corners and mode change only in the clock cycle after a 0-to-1 transition of `vsync`. With `vsync` held high or held low, the outputs keep their values whatever the other inputs do.
- R3: In `MODE_AUTO`, each frame edge loads every corner from `raw_x`/`raw_y`. Corner k (k = 0..3, standing for corners 1..4) occupies bits [k*10 +: 10] of the x buses and bits [k*9 +: 9] of the y buses, on both the raw inputs and the corner outputs.
- R4: A frame edge at which `override_req` is 1 and was 0 at the previous frame edge toggles the mode. An override held high over several frames toggles the mode only once.
- R5: The frame edge that enters `MODE_MANUAL` loads the raw corners and applies no button move.
- R6: In `MODE_MANUAL`, each frame edge applies one step to the selected corner while a button is held, so a held button moves the corner once per frame. Unselected corners and the raw inputs have no effect on the outputs.
- R7: Left decreases x by `STEP_X` (default 4) only if x >= `STEP_X`; otherwise x is unchanged.
- R8: Right increases x by `STEP_X` only if x <= 640 - `STEP_X`; otherwise x is unchanged.
- R9: Up decreases y by `STEP_Y` (default 4) only if y >= `STEP_Y`. Down increases y by `STEP_Y` only if y <= 480 - `STEP_Y`. Otherwise y is unchanged.
- R10: When several buttons are held, only the highest-priority one acts, in the order up, down, left, right. At most one axis moves per frame.
- R11: `cursor_x`/`cursor_y` show the corner picked by `corner_sel`, where code 0..3 selects corner 1..4. The same code chooses the corner that is edited.
- R12: The frame edge that leaves `MODE_MANUAL` reloads all corners from the raw inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vsync | input | 1 | Vertical sync; its rising edge marks a frame |
| btn_up | input | 1 | Move selected corner up (y decreases) |
| btn_down | input | 1 | Move selected corner down |
| btn_left | input | 1 | Move selected corner left |
| btn_right | input | 1 | Move selected corner right |
| override_req | input | 1 | Mode toggle request, rise-detected per frame |
| corner_sel | input | 2 | Selected corner, 0..3 |
| raw_x | input | 40 | Raw x of four corners, 10 bits each |
| raw_y | input | 36 | Raw y of four corners, 9 bits each |
| corner_x | output | 40 | Active x of four corners |
| corner_y | output | 36 | Active y of four corners |
| cursor_x | output | 10 | x of the selected corner |
| cursor_y | output | 9 | y of the selected corner |

## Verification
The assertions check four things on every cycle: outputs and mode hold between frame edges, automatic frames and manual exits reload the raw corners, unselected corners stay fixed during an edit frame, and no edit frame moves both axes. The bench's scenarios are needed for the arithmetic limits at and around each screen edge, the button priority order, the single toggle under a held override, the capture on entry to manual mode, and the cursor selection. The bench sweeps every corner through coordinates near 0, mid-screen and the far edges, and compares the outputs with a frame-by-frame model after every frame.

// File: rtl/corner_pkg.sv
package corner_pkg;
    typedef enum logic {
        MODE_AUTO   = 1'b0,
        MODE_MANUAL = 1'b1
    } mode_e;

    typedef struct packed {
        logic up;
        logic down;
        logic left;
        logic right;
    } dir_t;
endpackage

// File: rtl/frame_tick.sv
module frame_tick (
    input  logic clk,
    input  logic rst_n,
    input  logic vsync,
    output logic tick
);
    logic vs_q;

    always_ff @(posedge clk) begin
        if (!rst_n) vs_q <= 1'b1;
        else        vs_q <= vsync;
    end

    assign tick = vsync & ~vs_q;
endmodule

// File: rtl/corner_step.sv
module corner_step #(
    parameter int XW     = 10,
    parameter int YW     = 9,
    parameter int SCR_W  = 640,
    parameter int SCR_H  = 480,
    parameter int STEP_X = 4,
    parameter int STEP_Y = 4
) (
    input  corner_pkg::dir_t dir,
    input  logic [XW-1:0]    cur_x,
    input  logic [YW-1:0]    cur_y,
    output logic [XW-1:0]    nxt_x,
    output logic [YW-1:0]    nxt_y
);
    localparam logic [XW-1:0] SX    = XW'(STEP_X);
    localparam logic [YW-1:0] SY    = YW'(STEP_Y);
    localparam logic [XW-1:0] LIM_X = XW'(SCR_W - STEP_X);
    localparam logic [YW-1:0] LIM_Y = YW'(SCR_H - STEP_Y);

    always_comb begin
        nxt_x = cur_x;
        nxt_y = cur_y;
        if (dir.up) begin
            if (cur_y >= SY) nxt_y = cur_y - SY;
        end else if (dir.down) begin
            if (cur_y <= LIM_Y) nxt_y = cur_y + SY;
        end else if (dir.left) begin
            if (cur_x >= SX) nxt_x = cur_x - SX;
        end else if (dir.right) begin
            if (cur_x <= LIM_X) nxt_x = cur_x + SX;
        end
    end
endmodule

// File: rtl/corner_editor.sv
module corner_editor #(
    parameter int XW     = 10,
    parameter int YW     = 9,
    parameter int NC     = 4,
    parameter int SCR_W  = 640,
    parameter int SCR_H  = 480,
    parameter int STEP_X = 4,
    parameter int STEP_Y = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   vsync,
    input  logic                   btn_up,
    input  logic                   btn_down,
    input  logic                   btn_left,
    input  logic                   btn_right,
    input  logic                   override_req,
    input  logic [$clog2(NC)-1:0]  corner_sel,
    input  logic [NC*XW-1:0]       raw_x,
    input  logic [NC*YW-1:0]       raw_y,
    output logic [NC*XW-1:0]       corner_x,
    output logic [NC*YW-1:0]       corner_y,
    output logic [XW-1:0]          cursor_x,
    output logic [YW-1:0]          cursor_y
);
    import corner_pkg::*;

    localparam int SELW = $clog2(NC);

    mode_e state, state_nxt;
    logic  tick;
    logic  ovr_prev;
    logic  ovr_edge;
    logic  load_raw;
    logic  edit_en;
    dir_t  dir;

    logic [XW-1:0] cx [NC];
    logic [YW-1:0] cy [NC];

    frame_tick u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .vsync (vsync),
        .tick  (tick)
    );

    assign ovr_edge = override_req & ~ovr_prev;
    assign dir      = '{up: btn_up, down: btn_down, left: btn_left, right: btn_right};

    always_ff @(posedge clk) begin
        if (!rst_n)    ovr_prev <= 1'b0;
        else if (tick) ovr_prev <= override_req;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= MODE_AUTO;
        else        state <= state_nxt;
    end

    // next state
    always_comb begin
        state_nxt = state;
        unique case (state)
            MODE_AUTO:   if (tick && ovr_edge) state_nxt = MODE_MANUAL;
            MODE_MANUAL: if (tick && ovr_edge) state_nxt = MODE_AUTO;
            default:     state_nxt = MODE_AUTO;
        endcase
    end

    // output control decoded from state
    always_comb begin
        load_raw = 1'b0;
        edit_en  = 1'b0;
        unique case (state)
            MODE_AUTO:   load_raw = tick;
            MODE_MANUAL: begin
                load_raw = tick & ovr_edge;
                edit_en  = tick & ~ovr_edge;
            end
            default:     load_raw = tick;
        endcase
    end

    for (genvar k = 0; k < NC; k++) begin : g_corner
        logic [XW-1:0] nx;
        logic [YW-1:0] ny;
        logic          picked;

        assign picked = (corner_sel == SELW'(k));

        corner_step #(
            .XW(XW), .YW(YW), .SCR_W(SCR_W), .SCR_H(SCR_H),
            .STEP_X(STEP_X), .STEP_Y(STEP_Y)
        ) u_step (
            .dir   (dir),
            .cur_x (cx[k]),
            .cur_y (cy[k]),
            .nxt_x (nx),
            .nxt_y (ny)
        );

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cx[k] <= '0;
                cy[k] <= '0;
            end else if (load_raw) begin
                cx[k] <= raw_x[k*XW +: XW];
                cy[k] <= raw_y[k*YW +: YW];
            end else if (edit_en && picked) begin
                cx[k] <= nx;
                cy[k] <= ny;
            end
        end

        assign corner_x[k*XW +: XW] = cx[k];
        assign corner_y[k*YW +: YW] = cy[k];
    end

    assign cursor_x = cx[corner_sel];
    assign cursor_y = cy[corner_sel];
endmodule

// File: rtl/corner_editor_chk.sv
module corner_editor_chk #(
    parameter int XW = 10,
    parameter int YW = 9,
    parameter int NC = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  tick,
    input logic                  ovr_edge,
    input corner_pkg::mode_e     state,
    input logic [$clog2(NC)-1:0] corner_sel,
    input logic [NC*XW-1:0]      raw_x,
    input logic [NC*YW-1:0]      raw_y,
    input logic [NC*XW-1:0]      corner_x,
    input logic [NC*YW-1:0]      corner_y
);
    import corner_pkg::*;

    logic [$clog2(NC)-1:0] sel_d;
    logic [NC*XW-1:0]      keep_x;
    logic [NC*YW-1:0]      keep_y;

    always_ff @(posedge clk) sel_d <= corner_sel;

    always_comb begin
        keep_x = '1;
        keep_y = '1;
        keep_x[sel_d*XW +: XW] = '0;
        keep_y[sel_d*YW +: YW] = '0;
    end

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(corner_x) && $stable(corner_y)));

    assert_mode_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(state));

    assert_auto_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && state == MODE_AUTO) |=>
            (corner_x == $past(raw_x) && corner_y == $past(raw_y)));

    assert_exit_reload_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && state == MODE_MANUAL && ovr_edge) |=>
            (corner_x == $past(raw_x) && corner_y == $past(raw_y) && state == MODE_AUTO));

    assert_unselected_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && state == MODE_MANUAL && !ovr_edge) |=>
            ((((corner_x ^ $past(corner_x)) & keep_x) == '0) &&
             (((corner_y ^ $past(corner_y)) & keep_y) == '0)));

    assert_one_axis_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && state == MODE_MANUAL && !ovr_edge) |=>
            !((corner_x != $past(corner_x)) && (corner_y != $past(corner_y))));
endmodule

bind corner_editor corner_editor_chk #(.XW(XW), .YW(YW), .NC(NC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .ovr_edge   (ovr_edge),
    .state      (state),
    .corner_sel (corner_sel),
    .raw_x      (raw_x),
    .raw_y      (raw_y),
    .corner_x   (corner_x),
    .corner_y   (corner_y)
);

// File: tb/corner_editor_tb.sv
module corner_editor_tb;
    localparam int XW = 10, YW = 9, NC = 4;
    localparam int SW = 640, SH = 480, ST = 4;

    logic clk = 0, rst_n = 0, vsync = 0;
    logic btn_up = 0, btn_down = 0, btn_left = 0, btn_right = 0, override_req = 0;
    logic [1:0] corner_sel = 0;
    logic [NC*XW-1:0] raw_x = '0, corner_x;
    logic [NC*YW-1:0] raw_y = '0, corner_y;
    logic [XW-1:0] cursor_x;
    logic [YW-1:0] cursor_y;

    int checks = 0, errors = 0;
    int mx [NC], my [NC], rx [NC], ry [NC];
    bit mman = 0, mprev = 0;

    always #5 clk = ~clk;

    corner_editor u_dut (
        .clk(clk), .rst_n(rst_n), .vsync(vsync),
        .btn_up(btn_up), .btn_down(btn_down), .btn_left(btn_left), .btn_right(btn_right),
        .override_req(override_req), .corner_sel(corner_sel),
        .raw_x(raw_x), .raw_y(raw_y),
        .corner_x(corner_x), .corner_y(corner_y),
        .cursor_x(cursor_x), .cursor_y(cursor_y)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        for (int k = 0; k < NC; k++) begin
            check(tag, int'(corner_x[k*XW +: XW]), mx[k]);
            check(tag, int'(corner_y[k*YW +: YW]), my[k]);
        end
        check({tag, " R11 cursor_x"}, int'(cursor_x), mx[corner_sel]);
        check({tag, " R11 cursor_y"}, int'(cursor_y), my[corner_sel]);
    endtask

    task automatic set_raw(input int x0, input int y0);
        for (int k = 0; k < NC; k++) begin
            rx[k] = x0 + k;
            ry[k] = y0 + k;
            if (rx[k] > SW) rx[k] = SW - k;
            if (ry[k] > SH) ry[k] = SH - k;
            raw_x[k*XW +: XW] = XW'(rx[k]);
            raw_y[k*YW +: YW] = YW'(ry[k]);
        end
    endtask

    // model of one frame edge, from the requirements
    task automatic model_frame();
        bit edge_seen;
        int s;
        edge_seen = override_req && !mprev;
        mprev = override_req;
        s = corner_sel;
        if (!mman || edge_seen) begin
            for (int k = 0; k < NC; k++) begin mx[k] = rx[k]; my[k] = ry[k]; end
            if (edge_seen) mman = !mman;
        end else begin
            if (btn_up)         begin if (my[s] >= ST) my[s] -= ST; end
            else if (btn_down)  begin if (my[s] + ST <= SH) my[s] += ST; end
            else if (btn_left)  begin if (mx[s] >= ST) mx[s] -= ST; end
            else if (btn_right) begin if (mx[s] + ST <= SW) mx[s] += ST; end
        end
    endtask

    task automatic frame(input string tag);
        @(negedge clk) vsync = 1;
        model_frame();
        @(negedge clk) vsync = 0;
        @(negedge clk);
        check_all(tag);
    endtask

    task automatic press(input int d, input string tag);
        btn_up = (d == 0); btn_down = (d == 1); btn_left = (d == 2); btn_right = (d == 3);
        frame(tag);
        btn_up = 0; btn_down = 0; btn_left = 0; btn_right = 0;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int vx [10] = '{0, 1, 3, 4, 5, 320, 635, 636, 637, 640};
        int vy [10] = '{0, 2, 3, 4, 5, 240, 475, 476, 477, 480};
        for (int k = 0; k < NC; k++) begin mx[k] = 0; my[k] = 0; rx[k] = 0; ry[k] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check_all("R1 reset");

        // R3 automatic follow with several raw patterns
        set_raw(100, 50);  frame("R3 auto");
        set_raw(7, 401);   frame("R3 auto");
        set_raw(600, 9);   frame("R3 auto");

        // R2: no update while vsync held high or low
        @(negedge clk) vsync = 1; model_frame();
        @(negedge clk) set_raw(11, 22);
        repeat (4) @(negedge clk);
        check_all("R2 held high");
        vsync = 0;
        repeat (4) @(negedge clk);
        check_all("R2 held low");

        // R4 held override toggles once; R5 captures raw on entry
        override_req = 1;
        frame("R5 entry");
        set_raw(300, 300);
        frame("R4 held override");
        frame("R4 held override");
        override_req = 0;
        // R6 held button moves every frame, raw ignored
        corner_sel = 2;
        btn_right = 1;
        frame("R6 held");
        set_raw(1, 1);
        frame("R6 held raw ignored");
        frame("R6 held");
        btn_right = 0;
        // R10 priority combinations
        btn_up = 1; btn_left = 1; frame("R10 up over left");
        btn_up = 0; btn_down = 1; btn_right = 1; frame("R10 down over right");
        btn_down = 0; btn_left = 1; frame("R10 left over right");
        btn_up = 1; btn_down = 1; frame("R10 up over down");
        btn_up = 0; btn_down = 0; btn_left = 0; btn_right = 0;
        // R12 exit reloads
        override_req = 1; frame("R12 exit");
        override_req = 0; frame("R3 auto after exit");

        // sweep every corner over edge coordinates
        for (int s = 0; s < NC; s++) begin
            for (int i = 0; i < 10; i++) begin
                corner_sel = 2'(s);
                set_raw(vx[i] - (s % 2) * 0, vy[i]);
                frame("R3 sweep auto");
                override_req = 1; frame("R5 sweep entry");
                override_req = 0;
                press(2, "R7 left");
                press(3, "R8 right");
                press(3, "R8 right");
                press(2, "R7 left");
                press(0, "R9 up");
                press(1, "R9 down");
                press(1, "R9 down");
                press(0, "R9 up");
                override_req = 1; frame("R12 sweep exit");
                override_req = 0;
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule